// File: doc/BRIEF.md
# Three-Digit Decimal Event Counter

This block counts enabled clock edges in decimal, from 000 up to 999, and then wraps back to 000. It is assembled from identical one-digit stages that all run on a single clock. Each stage computes its next value with per-bit toggle terms rather than an adder and compare. A stage moves forward only when the count enable is high and every lower digit is at nine. Because of that condition, all digits that change on a carry change on the same edge.

The digits leave the block as one packed vector. The units digit sits in the lowest nibble, the tens digit in the next, and the hundreds digit in the top nibble. A one-cycle wrap flag shows that the next enabled edge will take the count from 999 to 000. The number of digits is a parameter, and three is the default.

Top module: `dec_chain_counter`

## Requirements
- R1: While `rst` is high at a rising clock edge, every digit becomes 0 on that edge, whatever the enable is. With `rst` high and `count_en` low, `wrap_o` is 0.
- R2: With `count_en` low, no digit changes at a clock edge.
- R3: With `count_en` high, the units digit (bits 3:0) steps up by one at each edge. From 9 it goes to 0.
- R4: The tens digit (bits 7:4) steps up by one at an edge only when `count_en` is high and the units digit is 9. From 9 it goes to 0.
- R5: The hundreds digit (bits 11:8) steps up by one at an edge only when `count_en` is high and both lower digits are 9. From 9 it goes to 0.
- R6: `wrap_o` is 1 exactly when `count_en` is high and all digits are 9.
- R7: An enabled edge taken while `wrap_o` is 1 leaves every digit at 0.
- R8: Every digit always holds a legal decimal value, 0 through 9.
- R9: Taken together, the digits follow the decimal count (n+1) mod 1000 on every enabled edge, across many patterns of enable gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| count_en | input | 1 | Advance the count on this edge |
| digits_o | output | 12 | Packed decimal digits; units digit in bits 3:0 |
| wrap_o | output | 1 | High when the count is 999 and enable is high |

## Verification
A wrong toggle term inside one stage shows at the next enabled edge. It appears either as a digit outside 0 to 9 or as a digit skipping a value. A broken carry between stages stays hidden until the lower digit reaches 9. It can therefore take up to ten enabled edges to appear for the tens digit and up to one hundred for the hundreds digit. For that reason the bench runs past the full 1000-count cycle and compares every digit on every edge.

// File: rtl/dec_counter_pkg.sv
package dec_counter_pkg;
  localparam int DIGIT_W = 4;
  typedef logic [DIGIT_W-1:0] digit_t;
  localparam digit_t DIGIT_MAX = 4'd9;
endpackage

// File: rtl/dec_digit_stage.sv
module dec_digit_stage
  import dec_counter_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   step_i,
  output digit_t digit_o,
  output logic   at_nine_o
);
  digit_t q;
  digit_t tgl;

  // toggle terms per bit weight
  always_comb begin
    tgl[0] = 1'b1;
    tgl[1] = ~q[3] & q[0];
    tgl[2] = q[1] & q[0];
    tgl[3] = (q[3] & q[0]) | (q[2] & q[1] & q[0]);
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else if (step_i) q <= q ^ tgl;
  end

  assign digit_o   = q;
  assign at_nine_o = q[3] & q[0];

  a_r8_digit_legal: assert property (@(posedge clk) disable iff (rst)
    q <= DIGIT_MAX);
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !step_i |=> $stable(q));
  a_r3_wrap_digit: assert property (@(posedge clk) disable iff (rst)
    (step_i && q == DIGIT_MAX) |=> q == '0);
  a_r3_step_digit: assert property (@(posedge clk) disable iff (rst)
    (step_i && q < DIGIT_MAX) |=> q == $past(q) + 4'd1);
endmodule

// File: rtl/dec_carry_chain.sv
module dec_carry_chain #(
  parameter int N_DIG = 3
) (
  input  logic             en_i,
  input  logic [N_DIG-1:0] nine_i,
  output logic [N_DIG-1:0] step_o,
  output logic             wrap_o
);
  logic [N_DIG:0] chain;
  assign chain[0] = en_i;
  for (genvar g = 0; g < N_DIG; g++) begin : g_link
    assign step_o[g]  = chain[g];
    assign chain[g+1] = chain[g] & nine_i[g];
  end
  assign wrap_o = chain[N_DIG];
endmodule

// File: rtl/dec_chain_counter.sv
module dec_chain_counter
  import dec_counter_pkg::*;
#(
  parameter int N_DIG = 3,
  localparam int VW = N_DIG * DIGIT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          count_en,
  output logic [VW-1:0] digits_o,
  output logic          wrap_o
);
  logic [N_DIG-1:0] nine;
  logic [N_DIG-1:0] step;

  dec_carry_chain #(.N_DIG(N_DIG)) u_chain (
    .en_i   (count_en),
    .nine_i (nine),
    .step_o (step),
    .wrap_o (wrap_o)
  );

  for (genvar g = 0; g < N_DIG; g++) begin : g_dig
    digit_t d;
    dec_digit_stage u_stage (
      .clk      (clk),
      .rst      (rst),
      .step_i   (step[g]),
      .digit_o  (d),
      .at_nine_o(nine[g])
    );
    assign digits_o[g*DIGIT_W +: DIGIT_W] = d;
  end

  a_r1_reset: assert property (@(posedge clk)
    rst |=> digits_o == '0);
  a_r7_rollover: assert property (@(posedge clk) disable iff (rst)
    wrap_o |=> digits_o == '0);
  a_r6_wrap_needs_en: assert property (@(posedge clk) disable iff (rst)
    wrap_o |-> count_en);
endmodule

// File: tb/tb_dec_chain_counter.sv
module tb_dec_chain_counter;
  logic clk = 0;
  logic rst;
  logic count_en;
  logic [11:0] digits_o;
  logic wrap_o;
  int checks = 0;
  int errors = 0;
  int model = 0;

  always #5 clk = ~clk;

  dec_chain_counter dut (.clk(clk), .rst(rst), .count_en(count_en),
                         .digits_o(digits_o), .wrap_o(wrap_o));

  function automatic logic [11:0] to_bcd(int v);
    return {4'(v / 100), 4'((v / 10) % 10), 4'(v % 10)};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one clock: drive en at negedge, check after the edge at next negedge
  task automatic tick(logic en);
    count_en = en;
    #1;
    chk("R6", 32'(wrap_o), 32'(en && model == 999));
    @(posedge clk);
    if (en) model = (model + 1) % 1000;
    @(negedge clk);
    chk("R9", 32'(digits_o), 32'(to_bcd(model)));
    chk("R8", 32'(digits_o[3:0] <= 9 && digits_o[7:4] <= 9 && digits_o[11:8] <= 9), 1);
  endtask

  task automatic t_reset();
    rst = 1; count_en = 1;
    @(posedge clk); @(negedge clk);
    model = 0;
    chk("R1", 32'(digits_o), 0);
    count_en = 0; #1;
    chk("R1", 32'(wrap_o), 0);
    rst = 0;
  endtask

  task automatic t_hold();
    for (int i = 0; i < 3; i++) tick(1);
    for (int i = 0; i < 4; i++) tick(0);
    chk("R2", 32'(digits_o), 32'(to_bcd(3)));
  endtask

  task automatic t_units_tens();
    for (int i = 0; i < 6; i++) tick(1);
    chk("R3", 32'(digits_o[3:0]), 9);
    chk("R4", 32'(digits_o[7:4]), 0);
    tick(1);
    chk("R3", 32'(digits_o[3:0]), 0);
    chk("R4", 32'(digits_o[7:4]), 1);
  endtask

  task automatic t_hundreds_gaps();
    for (int i = 0; i < 200; i++) tick((i % 7) != 3);
    while (model != 99) tick(1);
    tick(1);
    chk("R5", 32'(digits_o), 32'h100);
  endtask

  task automatic t_rollover();
    while (model != 999) tick(1);
    chk("R6", 32'(digits_o), 32'h999);
    tick(1);
    chk("R7", 32'(digits_o), 0);
    for (int i = 0; i < 1010; i++) tick(1);
  endtask

  task automatic t_reset_mid();
    rst = 1; count_en = 1;
    @(posedge clk); @(negedge clk);
    model = 0;
    chk("R1", 32'(digits_o), 0);
    rst = 0;
    tick(1);
    chk("R3", 32'(digits_o), 1);
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1; count_en = 0;
    @(negedge clk);
    t_reset();
    t_hold();
    t_units_tens();
    t_hundreds_gaps();
    t_rollover();
    t_reset_mid();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule